// File: doc/BRIEF.md
# Cold/Warm Reset Sequencer

This block orders the reset of a processor subsystem. A cold request (power-on reset, or any of several request sources) asserts every module reset and the clock-manager reset together. It then releases the clock-manager reset after a hold count and waits a settle count so that clocks can stabilise. A warm request first handshakes with the fabric through an active-low pending/acknowledge pair. It then reasserts the module resets and raises a safe-mode request toward the clock manager, and waits for that request to be acknowledged. Unless stretching is bypassed, it then holds reset for a fixed stretch count.

Both paths end in one shared release sequence. The interconnect reset is released first, then the processor core reset, then the processor peripheral reset, with a programmable gap between stages. A one-cycle completion pulse marks the end of the sequence. The general peripheral reset stays asserted until software clears it. All request and acknowledge inputs pass through a two-flop synchroniser. Every cycle count comes from one shared down-counter that is reloaded whenever the state changes.

Top module: `rst_sequencer`

## Requirements
- R1: While `rst` is high, `clkmgr_rst`, `ic_rst`, `core_rst`, `cpu_per_rst` and `periph_rst` are 1, `safe_req` and `done` are 0, and `fab_pend_n` is 1. Releasing `rst` starts the cold sequence exactly as a cold request that was last seen on the final reset cycle.
- R2: The bits of `cold_src` are ORed after a two-flop synchroniser. A 1 on any bit driven before clock edge k asserts all five resets from edge k+2 onward. The sequence stays in its first step for as long as any bit is 1.
- R3: `clkmgr_rst` falls HOLD_CYC clock edges after the last edge on which the synchronised cold request, or `rst`, was seen high.
- R4: `ic_rst` falls SETTLE_CYC edges after `clkmgr_rst` falls, and never falls while `clkmgr_rst` is 1.
- R5: In the release sequence, `core_rst` falls GAP_CYC edges after `ic_rst`. `cpu_per_rst` falls GAP_CYC edges after that, and `done` is 1 for exactly that one cycle.
- R6: `periph_rst` stays 1 after the release sequence completes. A 1 on `sw_per_release` in the idle running state clears it at the next edge. Outside that state, `sw_per_release` has no effect.
- R7: In the running state, a synchronised `warm_req` drives `fab_pend_n` to 0. No reset changes until the synchronised `fab_ack_n` reads 0.
- R8: When the fabric acknowledge is seen, `safe_req` rises and `ic_rst`, `core_rst`, `cpu_per_rst` and `periph_rst` reassert, all on the same edge. `clkmgr_rst` stays 0.
- R9: With `stretch_bypass`=0, a synchronised `safe_ack` drops `safe_req`. Reset is then held for STRETCH_CYC edges, after which `ic_rst` falls and `fab_pend_n` returns to 1 on the same edge.
- R10: With `stretch_bypass`=1, release starts at the later of two events: `safe_ack` seen high, or `warm_req` seen low. On that edge `safe_req` drops, `ic_rst` falls and `fab_pend_n` returns to 1.
- R11: A cold request seen in any warm state restarts the cold sequence at its first step. On that edge `clkmgr_rst` rises, `safe_req` falls and `fab_pend_n` returns to 1.
- R12: `warm_req` has no effect outside the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cold_src | input | NSRC | Cold reset request sources, active high, asynchronous |
| warm_req | input | 1 | Warm reset request (button level), active high, asynchronous |
| stretch_bypass | input | 1 | Static: 1 skips the warm stretch count |
| fab_ack_n | input | 1 | Fabric acknowledge of pending reset, active low, asynchronous |
| safe_ack | input | 1 | Clock-manager safe-mode acknowledge, asynchronous |
| sw_per_release | input | 1 | Software pulse that clears the peripheral reset |
| clkmgr_rst | output | 1 | Clock-manager cold reset |
| ic_rst | output | 1 | Interconnect and miscellaneous reset |
| core_rst | output | 1 | Processor core and snoop-control reset |
| cpu_per_rst | output | 1 | Processor peripheral reset |
| periph_rst | output | 1 | General peripheral reset, cleared by software |
| safe_req | output | 1 | Safe-mode request to the clock manager |
| fab_pend_n | output | 1 | Pending-reset request to the fabric, active low |
| done | output | 1 | One-cycle pulse when the release sequence completes |

## Verification
The bench keeps HOLD_CYC=32, SETTLE_CYC=96 and STRETCH_CYC=256 at their defaults and sets GAP_CYC to 16. Because the gap then differs from the hold count, a stage timed with the wrong count shows up as a wrong edge cycle. The full 256-cycle warm stretch, both orderings of the bypassed release, and a cold abort in the middle of a warm handshake all fit in a few thousand cycles. Every output edge is checked against its predicted cycle, counting the synchroniser latency.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_COLD_HOLD    = 3'd0,
        ST_COLD_SETTLE  = 3'd1,
        ST_DEA_IC       = 3'd2,
        ST_DEA_CORE     = 3'd3,
        ST_RUN          = 3'd4,
        ST_WARM_PEND    = 3'd5,
        ST_WARM_SAFE    = 3'd6,
        ST_WARM_STRETCH = 3'd7
    } seq_state_e;

    typedef struct packed {
        logic clkmgr_rst;
        logic ic_rst;
        logic core_rst;
        logic cpu_per_rst;
        logic safe_req;
        logic pend_n;
    } seq_drive_t;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // States that (re)assert the peripheral reset group
    function automatic logic grabs_periph(input seq_state_e s);
        return (s == ST_COLD_HOLD) || (s == ST_WARM_SAFE);
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int unsigned      W       = 1,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        logic held;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta <= RST_VAL[i];
                held <= RST_VAL[i];
            end else begin
                meta <= d[i];
                held <= meta;
            end
        end
        assign q[i] = held;
    end

endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign zero = (cnt == '0);

    p_count_down_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

    p_hold_at_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/rstseq_outmap.sv
module rstseq_outmap
    import rstseq_pkg::*;
(
    input  seq_state_e state,
    output seq_drive_t drv
);

    always_comb begin
        drv = '{clkmgr_rst: 1'b0, ic_rst: 1'b0, core_rst: 1'b0,
                cpu_per_rst: 1'b0, safe_req: 1'b0, pend_n: 1'b1};
        case (state)
            ST_COLD_HOLD: begin
                drv.clkmgr_rst  = 1'b1;
                drv.ic_rst      = 1'b1;
                drv.core_rst    = 1'b1;
                drv.cpu_per_rst = 1'b1;
            end
            ST_COLD_SETTLE: begin
                drv.ic_rst      = 1'b1;
                drv.core_rst    = 1'b1;
                drv.cpu_per_rst = 1'b1;
            end
            ST_DEA_IC: begin
                drv.core_rst    = 1'b1;
                drv.cpu_per_rst = 1'b1;
            end
            ST_DEA_CORE: begin
                drv.cpu_per_rst = 1'b1;
            end
            ST_RUN: ;
            ST_WARM_PEND: begin
                drv.pend_n      = 1'b0;
            end
            ST_WARM_SAFE: begin
                drv.ic_rst      = 1'b1;
                drv.core_rst    = 1'b1;
                drv.cpu_per_rst = 1'b1;
                drv.safe_req    = 1'b1;
                drv.pend_n      = 1'b0;
            end
            ST_WARM_STRETCH: begin
                drv.ic_rst      = 1'b1;
                drv.core_rst    = 1'b1;
                drv.cpu_per_rst = 1'b1;
                drv.pend_n      = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rstseq_pkg::*;
#(
    parameter int unsigned NSRC        = 3,
    parameter int unsigned HOLD_CYC    = 32,
    parameter int unsigned SETTLE_CYC  = 96,
    parameter int unsigned STRETCH_CYC = 256,
    parameter int unsigned GAP_CYC     = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] cold_src,
    input  logic            warm_req,
    input  logic            stretch_bypass,
    input  logic            fab_ack_n,
    input  logic            safe_ack,
    input  logic            sw_per_release,
    output logic            clkmgr_rst,
    output logic            ic_rst,
    output logic            core_rst,
    output logic            cpu_per_rst,
    output logic            periph_rst,
    output logic            safe_req,
    output logic            fab_pend_n,
    output logic            done
);

    localparam int unsigned MAX_CYC = max_of(max_of(HOLD_CYC, SETTLE_CYC),
                                             max_of(STRETCH_CYC, GAP_CYC));
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);

    // ---------------- input synchronisers ----------------
    logic [NSRC-1:0] cold_s;
    logic [2:0]      hs_s;
    logic            cold_any;
    logic            warm_s;
    logic            ack_n_s;
    logic            safe_ack_s;

    rstseq_sync #(.W(NSRC), .RST_VAL({NSRC{1'b0}})) u_cold_sync (
        .clk (clk),
        .rst (rst),
        .d   (cold_src),
        .q   (cold_s)
    );

    rstseq_sync #(.W(3), .RST_VAL(3'b010)) u_hs_sync (
        .clk (clk),
        .rst (rst),
        .d   ({safe_ack, fab_ack_n, warm_req}),
        .q   (hs_s)
    );

    assign cold_any   = |cold_s;
    assign warm_s     = hs_s[0];
    assign ack_n_s    = hs_s[1];
    assign safe_ack_s = hs_s[2];

    // ---------------- state machine ----------------
    seq_state_e    state;
    seq_state_e    nxt;
    seq_state_e    eff_nxt;
    logic          t_zero;
    logic          t_load;
    logic [CW-1:0] t_val;

    always_comb begin
        nxt = state;
        case (state)
            ST_COLD_HOLD:    if (t_zero) nxt = ST_COLD_SETTLE;
            ST_COLD_SETTLE:  if (t_zero) nxt = ST_DEA_IC;
            ST_DEA_IC:       if (t_zero) nxt = ST_DEA_CORE;
            ST_DEA_CORE:     if (t_zero) nxt = ST_RUN;
            ST_RUN:          if (warm_s) nxt = ST_WARM_PEND;
            ST_WARM_PEND:    if (!ack_n_s) nxt = ST_WARM_SAFE;
            ST_WARM_SAFE: begin
                if (safe_ack_s && (!stretch_bypass || !warm_s)) begin
                    nxt = stretch_bypass ? ST_DEA_IC : ST_WARM_STRETCH;
                end
            end
            ST_WARM_STRETCH: if (t_zero) nxt = ST_DEA_IC;
            default:         nxt = ST_COLD_HOLD;
        endcase
        if (cold_any) nxt = ST_COLD_HOLD;
    end

    assign eff_nxt = rst ? ST_COLD_HOLD : nxt;
    assign t_load  = rst || cold_any || (eff_nxt != state);

    always_comb begin
        case (eff_nxt)
            ST_COLD_HOLD:    t_val = CW'(HOLD_CYC - 1);
            ST_COLD_SETTLE:  t_val = CW'(SETTLE_CYC - 1);
            ST_DEA_IC,
            ST_DEA_CORE:     t_val = CW'(GAP_CYC - 1);
            ST_WARM_STRETCH: t_val = CW'(STRETCH_CYC - 1);
            default:         t_val = '0;
        endcase
    end

    rstseq_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    logic per_hold;
    logic done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_COLD_HOLD;
            per_hold <= 1'b1;
            done_q   <= 1'b0;
        end else begin
            state  <= nxt;
            done_q <= (nxt == ST_RUN) && (state != ST_RUN);
            if (grabs_periph(nxt)) begin
                per_hold <= 1'b1;
            end else if (state == ST_RUN && nxt == ST_RUN && sw_per_release) begin
                per_hold <= 1'b0;
            end
        end
    end

    // ---------------- output decode ----------------
    seq_drive_t drv;

    rstseq_outmap u_outmap (
        .state (state),
        .drv   (drv)
    );

    assign clkmgr_rst  = drv.clkmgr_rst;
    assign ic_rst      = drv.ic_rst;
    assign core_rst    = drv.core_rst;
    assign cpu_per_rst = drv.cpu_per_rst;
    assign safe_req    = drv.safe_req;
    assign fab_pend_n  = drv.pend_n;
    assign periph_rst  = per_hold;
    assign done        = done_q;

    // ---------------- assertions ----------------
    p_ic_after_clkmgr_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ic_rst) |-> !clkmgr_rst);

    p_core_after_ic_r5: assert property (@(posedge clk) disable iff (rst)
        !core_rst |-> !ic_rst);

    p_cpuper_after_core_r5: assert property (@(posedge clk) disable iff (rst)
        !cpu_per_rst |-> !core_rst);

    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_periph_sw_only_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(periph_rst) |-> ($past(sw_per_release) && !cpu_per_rst));

    p_safe_inside_warm_r8: assert property (@(posedge clk) disable iff (rst)
        safe_req |-> (ic_rst && !fab_pend_n && !clkmgr_rst));

    p_cold_wins_r11: assert property (@(posedge clk) disable iff (rst)
        cold_any |=> (clkmgr_rst && !safe_req && fab_pend_n));

endmodule

// File: tb/rst_sequencer_tb.sv
module rst_sequencer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC    = 3;
    localparam int HOLD    = 32;
    localparam int SETTLE  = 96;
    localparam int STRETCH = 256;
    localparam int GAP     = 16;
    localparam int LAT     = 3;   // drive-to-response edges through the synchroniser

    localparam int S_CLK  = 0;
    localparam int S_IC   = 1;
    localparam int S_CORE = 2;
    localparam int S_CPU  = 3;
    localparam int S_PER  = 4;
    localparam int S_SAFE = 5;
    localparam int S_PEND = 6;
    localparam int S_DONE = 7;

    logic            clk;
    logic            rst;
    logic [NSRC-1:0] cold_src;
    logic            warm_req;
    logic            stretch_bypass;
    logic            fab_ack_n;
    logic            safe_ack;
    logic            sw_per_release;
    logic            clkmgr_rst;
    logic            ic_rst;
    logic            core_rst;
    logic            cpu_per_rst;
    logic            periph_rst;
    logic            safe_req;
    logic            fab_pend_n;
    logic            done;

    rst_sequencer #(
        .NSRC(NSRC), .HOLD_CYC(HOLD), .SETTLE_CYC(SETTLE),
        .STRETCH_CYC(STRETCH), .GAP_CYC(GAP)
    ) u_dut (
        .clk            (clk),
        .rst            (rst),
        .cold_src       (cold_src),
        .warm_req       (warm_req),
        .stretch_bypass (stretch_bypass),
        .fab_ack_n      (fab_ack_n),
        .safe_ack       (safe_ack),
        .sw_per_release (sw_per_release),
        .clkmgr_rst     (clkmgr_rst),
        .ic_rst         (ic_rst),
        .core_rst       (core_rst),
        .cpu_per_rst    (cpu_per_rst),
        .periph_rst     (periph_rst),
        .safe_req       (safe_req),
        .fab_pend_n     (fab_pend_n),
        .done           (done)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    sig;
        logic  val;
        int    at;
        string req;
    } ev_t;

    ev_t        evq[$];
    int         nchk = 0;
    int         nfail = 0;
    bit         mon_en = 0;
    bit         finished = 0;
    logic [7:0] prev;

    function automatic logic [7:0] obs_now();
        return {done, fab_pend_n, safe_req, periph_rst,
                cpu_per_rst, core_rst, ic_rst, clkmgr_rst};
    endfunction

    task automatic expect_ev(input int sig, input logic val, input int at, input string req);
        ev_t e;
        e.sig = sig; e.val = val; e.at = at; e.req = req;
        evq.push_back(e);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // shared release tail starting from the edge on which ic_rst falls (R5)
    task automatic expect_tail(input int t_ic);
        expect_ev(S_CORE, 1'b0, t_ic + GAP, "R5");
        expect_ev(S_CPU,  1'b0, t_ic + 2 * GAP, "R5");
        expect_ev(S_DONE, 1'b1, t_ic + 2 * GAP, "R5");
        expect_ev(S_DONE, 1'b0, t_ic + 2 * GAP + 1, "R5");
    endtask

    // d = last edge on which the cold request was seen (R3, R4)
    task automatic expect_cold_release(input int d);
        expect_ev(S_CLK, 1'b0, d + HOLD, "R3");
        expect_ev(S_IC,  1'b0, d + HOLD + SETTLE, "R4");
        expect_tail(d + HOLD + SETTLE);
    endtask

    task automatic check_drained(input string req);
        check(evq.size() == 0, req, "outstanding expected edges", evq.size(), 0);
    endtask

    task automatic release_periph();
        int k;
        k = cyc;
        sw_per_release = 1'b1;
        expect_ev(S_PER, 1'b0, k + 1, "R6");
        step(1);
        sw_per_release = 1'b0;
        step(3);
        check_drained("R6");
    endtask

    task automatic warm_enter(input int dummy);
        int k;
        int m;
        k = cyc + dummy;
        warm_req = 1'b1;
        expect_ev(S_PEND, 1'b0, k + LAT, "R7");
        step(8);
        check(ic_rst == 1'b0 && periph_rst == 1'b0, "R7", "resets before fabric ack",
              {ic_rst, periph_rst}, 0);
        m = cyc;
        fab_ack_n = 1'b0;
        expect_ev(S_IC,   1'b1, m + LAT, "R8");
        expect_ev(S_CORE, 1'b1, m + LAT, "R8");
        expect_ev(S_CPU,  1'b1, m + LAT, "R8");
        expect_ev(S_PER,  1'b1, m + LAT, "R8");
        expect_ev(S_SAFE, 1'b1, m + LAT, "R8");
        step(8);
        check(clkmgr_rst == 1'b0, "R8", "clock-manager reset during warm", clkmgr_rst, 0);
    endtask

    // scoreboard monitor: every output edge must match the head of the queue
    always @(negedge clk) begin
        if (mon_en) begin : mon
            logic [7:0] o;
            o = obs_now();
            for (int i = 0; i < 8; i++) begin
                if (o[i] !== prev[i]) begin
                    nchk++;
                    if (evq.size() == 0) begin
                        nfail++;
                        $display("FAIL unexpected edge (R6, R7, R12) sig=%0d actual=%b@%0d expected=no change",
                                 i, o[i], cyc);
                    end else begin : pop
                        ev_t e;
                        e = evq.pop_front();
                        if (e.sig != i || e.val !== o[i] || e.at != cyc) begin
                            nfail++;
                            $display("FAIL %s sig=%0d actual=%b@%0d expected sig=%0d %b@%0d",
                                     e.req, i, o[i], cyc, e.sig, e.val, e.at);
                        end
                    end
                end
            end
            prev = o;
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin : driver
        int r;
        int k;
        int s;
        int w;
        int c;
        logic [7:0] o;

        rst = 1'b1;
        cold_src = '0;
        warm_req = 1'b0;
        stretch_bypass = 1'b0;
        fab_ack_n = 1'b1;
        safe_ack = 1'b0;
        sw_per_release = 1'b0;
        step(5);

        // R1: reset state, then power-on release acts as a cold request
        o = obs_now();
        check(o == 8'h5F, "R1", "outputs under reset", int'(o), 8'h5F);
        prev = o;
        mon_en = 1'b1;
        r = cyc;
        expect_cold_release(r);
        rst = 1'b0;

        // R6 and R12: software release and warm pulse during release are ignored
        wait_to(r + HOLD + SETTLE + 2);
        sw_per_release = 1'b1;
        warm_req = 1'b1;
        step(1);
        sw_per_release = 1'b0;
        step(2);
        warm_req = 1'b0;
        wait_to(r + HOLD + SETTLE + 2 * GAP + 4);
        check_drained("R5");
        check(periph_rst == 1'b1, "R6", "peripheral reset after sequence", periph_rst, 1);
        release_periph();

        // R9: warm reset with stretch
        warm_enter(0);
        s = cyc;
        safe_ack = 1'b1;
        expect_ev(S_SAFE, 1'b0, s + LAT, "R9");
        expect_ev(S_IC,   1'b0, s + LAT + STRETCH, "R9");
        expect_ev(S_PEND, 1'b1, s + LAT + STRETCH, "R9");
        expect_tail(s + LAT + STRETCH);
        step(6);
        warm_req = 1'b0;
        fab_ack_n = 1'b1;
        safe_ack = 1'b0;
        wait_to(s + LAT + STRETCH + 2 * GAP + 4);
        check_drained("R9");
        release_periph();

        // R10: bypass, acknowledge first, button released later
        stretch_bypass = 1'b1;
        warm_enter(0);
        safe_ack = 1'b1;
        step(20);
        check(ic_rst == 1'b1, "R10", "held until warm release", ic_rst, 1);
        w = cyc;
        warm_req = 1'b0;
        expect_ev(S_IC,   1'b0, w + LAT, "R10");
        expect_ev(S_SAFE, 1'b0, w + LAT, "R10");
        expect_ev(S_PEND, 1'b1, w + LAT, "R10");
        expect_tail(w + LAT);
        step(5);
        fab_ack_n = 1'b1;
        safe_ack = 1'b0;
        wait_to(w + LAT + 2 * GAP + 4);
        check_drained("R10");
        release_periph();

        // R10: bypass, button released first, acknowledge later
        warm_enter(0);
        warm_req = 1'b0;
        step(20);
        check(ic_rst == 1'b1, "R10", "held until safe acknowledge", ic_rst, 1);
        s = cyc;
        safe_ack = 1'b1;
        expect_ev(S_IC,   1'b0, s + LAT, "R10");
        expect_ev(S_SAFE, 1'b0, s + LAT, "R10");
        expect_ev(S_PEND, 1'b1, s + LAT, "R10");
        expect_tail(s + LAT);
        step(5);
        fab_ack_n = 1'b1;
        safe_ack = 1'b0;
        wait_to(s + LAT + 2 * GAP + 4);
        check_drained("R10");
        release_periph();

        // R11: cold request aborts a warm sequence, held for 4 cycles
        stretch_bypass = 1'b0;
        warm_enter(0);
        c = cyc;
        cold_src = 3'b100;
        expect_ev(S_CLK,  1'b1, c + LAT, "R11");
        expect_ev(S_SAFE, 1'b0, c + LAT, "R11");
        expect_ev(S_PEND, 1'b1, c + LAT, "R11");
        expect_cold_release(c + 4 + 2);
        step(1);
        warm_req = 1'b0;
        fab_ack_n = 1'b1;
        step(3);
        cold_src = '0;
        wait_to(c + 6 + HOLD + SETTLE + 2 * GAP + 4);
        check_drained("R11");
        release_periph();

        // R2: cold request from running state on another source bit
        c = cyc;
        cold_src = 3'b001;
        expect_ev(S_CLK,  1'b1, c + LAT, "R2");
        expect_ev(S_IC,   1'b1, c + LAT, "R2");
        expect_ev(S_CORE, 1'b1, c + LAT, "R2");
        expect_ev(S_CPU,  1'b1, c + LAT, "R2");
        expect_ev(S_PER,  1'b1, c + LAT, "R2");
        expect_cold_release(c + 2 + 2);
        step(2);
        cold_src = '0;
        wait_to(c + 4 + HOLD + SETTLE + 2 * GAP + 4);
        check_drained("R2");
        check(periph_rst == 1'b1, "R2", "peripheral reset after cold", periph_rst, 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule